// File: doc/BRIEF.md
# Byte-Lane Partial Store Aligner

This block turns one store request into what a 32-bit little-endian memory port needs: a four-bit byte-enable mask, a write-data word whose bytes already sit in their memory lanes, and a 32-bit per-bit write enable. A request gives a register value, the two low address bits and a store kind. The kind is one of five: byte, halfword, full word, or one of the two partial-word stores. Each partial-word store writes one to four bytes, and how many depends on the offset. An 8-bit plane mask is copied into all four byte lanes and gates single bits. Memory with per-bit write enables can then skip a read/modify/write cycle when only some planes may change.

Lane 0 holds bits 7:0 and lane 3 holds bits 31:24. The right-hand partial store at offset k puts register bytes 0 upward into memory lanes k through 3. The left-hand partial store at offset k puts the top register bytes into lanes 0 through k. A misaligned halfword or word store writes nothing and raises a one-cycle alignment-error flag. A reserved kind code does the same. All outputs are registered and appear one cycle after the request.

Top module: `store_lane_aligner`

## Requirements
- R1: While rst_n is low and after it is released, with no request made, out_valid, align_err, byte_en, wr_data and bit_en are all zero.
- R2: out_valid is high in exactly the cycles that follow a cycle in which req_valid was high.
- R3: Store kind 0 (byte) at offset k enables only lane k, and register bits 7:0 appear in that lane.
- R4: Store kind 1 (halfword) at offset 0 or 2 enables lanes k and k+1, which carry register bytes 0 and 1. At offset 1 or 3 it is misaligned.
- R5: Store kind 2 (word) at offset 0 enables all four lanes with the register value unchanged. At any other offset it is misaligned.
- R6: Store kind 4 (right partial) at offset k enables lanes k through 3, and lane i carries register byte i-k. At offset 0 this equals a word store, and at offset 3 only register byte 0 goes into lane 3.
- R7: Store kind 3 (left partial) at offset k enables lanes 0 through k, and lane i carries register byte i+3-k. At offset 3 all four bytes are written, and at offset 0 only register byte 3 goes into lane 0.
- R8: A misaligned request, or a request with reserved kind code 5, 6 or 7, yields byte_en, wr_data and bit_en all zero, with align_err high for that single output cycle. align_err is low for every legal request.
- R9: bit_en bit 8i+j equals byte_en[i] AND plane mask bit j. Every wr_data lane whose byte enable is 0 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Store request present this cycle |
| req_kind | input | 3 | Store kind: 0 byte, 1 halfword, 2 word, 3 left partial, 4 right partial, 5-7 reserved |
| addr_lo | input | 2 | Low two bits of the byte address |
| reg_data | input | 32 | Register value to store |
| plane_mask | input | 8 | Per-bit write enable applied to every byte lane |
| out_valid | output | 1 | Registered outputs belong to a request |
| byte_en | output | 4 | Per-lane write enable, bit i for bits 8i+7:8i |
| wr_data | output | 32 | Lane-aligned write data, zero in disabled lanes |
| bit_en | output | 32 | Per-bit write enable |
| align_err | output | 1 | One-cycle flag for a misaligned or reserved request |

## Verification
The assertions assume that req_valid, req_kind and addr_lo are driven to known values at every sampled edge once reset is released. They also assume that req_valid is low for the whole reset period, because the latency property compares out_valid with the request from the previous cycle. The stimulus sets every input from time zero and holds req_valid low until reset is released. It changes inputs only on falling edges, so every rising edge samples settled values. It covers all eight kind codes at all four offsets, back-to-back requests, idle gaps, and plane masks of all ones, all zeros and mixed patterns.

// File: rtl/sla_pkg.sv
// Shared definitions for the byte-lane partial store aligner.
// Assumes a little-endian port: lane 0 is the least significant byte.
package sla_pkg;
    localparam int DATA_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int OFS_W  = $clog2(LANES);

    typedef enum logic [2:0] {
        KIND_BYTE  = 3'd0,
        KIND_HALF  = 3'd1,
        KIND_WORD  = 3'd2,
        KIND_LEFT  = 3'd3,
        KIND_RIGHT = 3'd4
    } store_kind_t;
endpackage

// File: rtl/sla_lane_decode.sv
// Decodes store kind and lane offset into a lane-enable mask, a shift
// direction/amount for the data path, and an error flag.
// Assumes kind codes outside the package enum are reserved.
module sla_lane_decode
    import sla_pkg::*;
#(
    parameter int NLANES = LANES,
    parameter int OW     = OFS_W
) (
    input  logic [2:0]        kind,
    input  logic [OW-1:0]     ofs,
    output logic [NLANES-1:0] lane_en,
    output logic              shift_down,
    output logic [OW-1:0]     shift_amt,
    output logic              bad
);
    localparam logic [NLANES-1:0] ALL_ONE = {NLANES{1'b1}};
    localparam logic [OW-1:0]     TOP_OFS = OW'(NLANES - 1);

    // Purpose: choose the enabled lanes and the data shift for each kind.
    always_comb begin
        lane_en    = '0;
        shift_down = 1'b0;
        shift_amt  = ofs;
        bad        = 1'b0;
        case (kind)
            KIND_BYTE: lane_en = NLANES'(1) << ofs;
            KIND_HALF: begin
                if (ofs[0]) bad = 1'b1;
                else        lane_en = NLANES'(3) << ofs;
            end
            KIND_WORD: begin
                if (ofs != '0) bad = 1'b1;
                else           lane_en = ALL_ONE;
            end
            KIND_RIGHT: lane_en = ALL_ONE << ofs;
            KIND_LEFT: begin
                shift_down = 1'b1;
                shift_amt  = TOP_OFS - ofs;
                lane_en    = ALL_ONE >> (TOP_OFS - ofs);
            end
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/sla_data_align.sv
// Moves register bytes into their memory lanes by a whole-lane shift and
// zeroes every lane that is not enabled.
// Assumes shift_amt is below the lane count.
module sla_data_align
    import sla_pkg::*;
#(
    parameter int DW     = DATA_W,
    parameter int LW     = LANE_W,
    parameter int NLANES = DW / LW,
    parameter int OW     = $clog2(NLANES)
) (
    input  logic [DW-1:0]     din,
    input  logic              shift_down,
    input  logic [OW-1:0]     shift_amt,
    input  logic [NLANES-1:0] lane_en,
    output logic [DW-1:0]     dout
);
    logic [DW-1:0] shifted;

    // Purpose: whole-lane shift toward higher lanes, or lower for left stores.
    always_comb begin
        if (shift_down) shifted = din >> (int'(shift_amt) * LW);
        else            shifted = din << (int'(shift_amt) * LW);
    end

    // One gate per lane clears the lanes that are not written.
    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        assign dout[i*LW +: LW] = lane_en[i] ? shifted[i*LW +: LW] : '0;
    end
endmodule

// File: rtl/sla_plane_gate.sv
// Copies the plane mask into every lane and ANDs it with the lane enable,
// giving a per-bit write enable.
// Assumes the mask is one lane wide.
module sla_plane_gate #(
    parameter int LW     = 8,
    parameter int NLANES = 4
) (
    input  logic [LW-1:0]        pmask,
    input  logic [NLANES-1:0]    lane_en,
    output logic [NLANES*LW-1:0] bit_en
);
    // Each lane receives the mask only when the lane is written.
    for (genvar i = 0; i < NLANES; i++) begin : g_plane
        assign bit_en[i*LW +: LW] = pmask & {LW{lane_en[i]}};
    end
endmodule

// File: rtl/store_lane_aligner.sv
// Top of the partial store aligner: decodes a store request, aligns the
// data, gates planes, and registers every output one cycle later.
// Assumes synchronous active-low reset; outputs hold between requests
// except out_valid and align_err, which drop to zero.
module store_lane_aligner
    import sla_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [OFS_W-1:0]  addr_lo,
    input  logic [DATA_W-1:0] reg_data,
    input  logic [LANE_W-1:0] plane_mask,
    output logic              out_valid,
    output logic [LANES-1:0]  byte_en,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] bit_en,
    output logic              align_err
);
    logic [LANES-1:0]  dec_en;
    logic              dec_down;
    logic [OFS_W-1:0]  dec_amt;
    logic              dec_bad;
    logic [DATA_W-1:0] algn_data;
    logic [DATA_W-1:0] gate_bits;

    sla_lane_decode #(.NLANES(LANES), .OW(OFS_W)) u_decode (
        .kind       (req_kind),
        .ofs        (addr_lo),
        .lane_en    (dec_en),
        .shift_down (dec_down),
        .shift_amt  (dec_amt),
        .bad        (dec_bad)
    );

    sla_data_align #(.DW(DATA_W), .LW(LANE_W), .NLANES(LANES), .OW(OFS_W)) u_align (
        .din        (reg_data),
        .shift_down (dec_down),
        .shift_amt  (dec_amt),
        .lane_en    (dec_en),
        .dout       (algn_data)
    );

    sla_plane_gate #(.LW(LANE_W), .NLANES(LANES)) u_gate (
        .pmask   (plane_mask),
        .lane_en (dec_en),
        .bit_en  (gate_bits)
    );

    // Purpose: capture the aligned result of a valid request for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            align_err <= 1'b0;
            byte_en   <= '0;
            wr_data   <= '0;
            bit_en    <= '0;
        end else begin
            out_valid <= req_valid;
            align_err <= req_valid & dec_bad;
            if (req_valid) begin
                byte_en <= dec_en;
                wr_data <= algn_data;
                bit_en  <= gate_bits;
            end
        end
    end
endmodule

// File: rtl/store_lane_aligner_chk.sv
// Property checker for store_lane_aligner, attached by bind below.
// Assumes request inputs are known at every edge after reset release.
module store_lane_aligner_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [2:0]  req_kind,
    input logic [1:0]  addr_lo,
    input logic [31:0] reg_data,
    input logic        out_valid,
    input logic [3:0]  byte_en,
    input logic [31:0] wr_data,
    input logic [31:0] bit_en,
    input logic        align_err
);
    logic [31:0] lane_bits;
    assign lane_bits = {{8{byte_en[3]}}, {8{byte_en[2]}}, {8{byte_en[1]}}, {8{byte_en[0]}}};

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(req_valid));

    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (out_valid && byte_en == 4'h0 && bit_en == 32'h0));

    assert_legal_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !align_err) |-> (byte_en != 4'h0));

    assert_lane_confined_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((bit_en & ~lane_bits) == 32'h0) && ((wr_data & ~lane_bits) == 32'h0));

    assert_word_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd2 && addr_lo == 2'd0) |=>
            (byte_en == 4'hF && wr_data == $past(reg_data)));

    assert_right_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd4) |=> (byte_en[3] && !align_err));

    assert_left_bottom_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd3) |=> (byte_en[0] && !align_err));
endmodule

bind store_lane_aligner store_lane_aligner_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .addr_lo   (addr_lo),
    .reg_data  (reg_data),
    .out_valid (out_valid),
    .byte_en   (byte_en),
    .wr_data   (wr_data),
    .bit_en    (bit_en),
    .align_err (align_err)
);

// File: tb/store_lane_aligner_tb_top.sv
// Scoreboard bench: the driver computes expected results from the
// requirements and queues them; the monitor compares on falling edges.
module store_lane_aligner_tb_top;
    typedef struct packed {
        logic [3:0]  be;
        logic [31:0] data;
        logic [31:0] bits;
        logic        err;
        logic [2:0]  kind;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [1:0]  addr_lo = 2'd0;
    logic [31:0] reg_data = 32'h0;
    logic [7:0]  plane_mask = 8'h0;
    logic        out_valid;
    logic [3:0]  byte_en;
    logic [31:0] wr_data;
    logic [31:0] bit_en;
    logic        align_err;

    int checks = 0;
    int failures = 0;
    exp_t expq[$];
    logic prev_req = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    store_lane_aligner dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .addr_lo    (addr_lo),
        .reg_data   (reg_data),
        .plane_mask (plane_mask),
        .out_valid  (out_valid),
        .byte_en    (byte_en),
        .wr_data    (wr_data),
        .bit_en     (bit_en),
        .align_err  (align_err)
    );

    function automatic string req_of(input logic [2:0] k, input logic e);
        if (e) return "R8";
        case (k)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R7";
            3'd4: return "R6";
            default: return "R8";
        endcase
    endfunction

    // Expected result from the lane rules of R3-R9, lane by lane.
    function automatic exp_t model(input logic [2:0] k, input int o,
                                   input logic [31:0] d, input logic [7:0] pm);
        exp_t e;
        e = '0;
        e.kind = k;
        for (int i = 0; i < 4; i++) begin
            int src;
            src = -1;
            case (k)
                3'd0: if (i == o) src = 0;
                3'd1: if (o % 2 == 0 && (i == o || i == o + 1)) src = i - o;
                3'd2: if (o == 0) src = i;
                3'd3: if (i <= o) src = i + 3 - o;
                3'd4: if (i >= o) src = i - o;
                default: src = -1;
            endcase
            if (src >= 0) begin
                e.be[i] = 1'b1;
                e.data[i*8 +: 8] = d[src*8 +: 8];
                e.bits[i*8 +: 8] = pm;
            end
        end
        e.err = (k > 3'd4) || (k == 3'd1 && o % 2 != 0) || (k == 3'd2 && o != 0);
        return e;
    endfunction

    task automatic send(input logic [2:0] k, input int o,
                        input logic [31:0] d, input logic [7:0] pm);
        @(negedge clk);
        req_valid  = 1'b1;
        req_kind   = k;
        addr_lo    = 2'(o);
        reg_data   = d;
        plane_mask = pm;
        expq.push_back(model(k, o, d, pm));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_kind  = 3'd7;
            reg_data  = 32'hFFFF_FFFF;
        end
    endtask

    // Purpose: remember whether a request was sampled at this edge.
    always @(posedge clk) prev_req <= rst_n ? req_valid : 1'b0;

    // Purpose: compare timing each cycle and pop the scoreboard on results.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (out_valid !== prev_req) begin
                failures++;
                $display("FAIL R2 out_valid actual=%b expected=%b", out_valid, prev_req);
            end
            if (out_valid === 1'b1) begin
                if (expq.size() == 0) begin
                    failures++;
                    $display("FAIL R2 unexpected result actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    checks++;
                    if (byte_en !== e.be || wr_data !== e.data || bit_en !== e.bits ||
                        align_err !== e.err) begin
                        failures++;
                        $display("FAIL %s kind=%0d actual be=%h data=%h bits=%h err=%b expected be=%h data=%h bits=%h err=%b",
                                 req_of(e.kind, e.err), e.kind, byte_en, wr_data, bit_en,
                                 align_err, e.be, e.data, e.bits, e.err);
                    end
                end
            end
        end
    end

    // Purpose: end a hung run as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while held in reset
        checks++;
        if (out_valid !== 1'b0 || align_err !== 1'b0 || byte_en !== 4'h0 ||
            wr_data !== 32'h0 || bit_en !== 32'h0) begin
            failures++;
            $display("FAIL R1 in reset actual v=%b e=%b be=%h expected 0 0 0",
                     out_valid, align_err, byte_en);
        end
        rst_n = 1'b1;
        idle(2);
        // R1: still quiet after release with no request
        checks++;
        if (out_valid !== 1'b0 || byte_en !== 4'h0 || bit_en !== 32'h0) begin
            failures++;
            $display("FAIL R1 after release actual v=%b be=%h expected 0 0",
                     out_valid, byte_en);
        end
        // R3 R4 R5 R6 R7 R8: every kind code at every offset, full mask
        for (int k = 0; k < 8; k++)
            for (int o = 0; o < 4; o++)
                send(3'(k), o, 32'h3322_1100 + 32'(k * 16 + o), 8'hFF);
        idle(3);
        // R9: plane mask patterns on back-to-back right and left stores
        for (int o = 0; o < 4; o++) send(3'd4, o, 32'hDDCC_BBAA, 8'h00);
        for (int o = 0; o < 4; o++) send(3'd3, o, 32'h8765_4321, 8'hA5);
        send(3'd1, 2, 32'hCAFE_F00D, 8'h0F);
        send(3'd0, 3, 32'h0000_0099, 8'h81);
        idle(2);
        // R6 R7 R8: random mix with idle gaps
        for (int n = 0; n < 200; n++) begin
            send(3'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                 $urandom, 8'($urandom));
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        idle(3);
        done = 1'b1;
        checks++;
        if (expq.size() != 0) begin
            failures++;
            $display("FAIL R2 missing results actual=%0d expected=0", expq.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule